// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the register side of a four-channel DMA controller whose host port is one byte wide. It holds a base and a current copy of a 16-bit address and a 16-bit word count for each channel, plus a six-bit mode register per channel. Software reads and writes the 16-bit registers one byte at a time. A single byte-pointer flip-flop, shared by all channels, decides which half each access touches. A dedicated command port puts the pointer back on the low byte.

The per-channel mode registers are all written through one mode port. The low two bits of the written byte pick the channel. The transfer engine is outside this block. It sends back stepped current values on an update port and raises a terminal-count pulse per channel. The block then either reloads the current registers from the base registers (autoinitialize) or latches a terminal-count status bit. A master-clear command returns the control state to idle.

Port codes on `addr`: 0..7 are the channel registers, with even codes selecting the address register and odd codes the count register, and the channel number in `addr[2:1]`. Code 8 is master clear, code 9 is the mode port and code 10 is clear-byte-pointer.

Top module: `dma_regfile_top`

## Requirements
- R1: After the pointer is cleared, the first access (read or write) to any channel register uses bits [7:0] and the next one uses bits [15:8]; the pointer flips on every channel-register access. A write loads the addressed byte of both the base and the current copy, and `rdata` returns the addressed byte of the current copy.
- R2: A write of any data value to port 10 returns the pointer to the low byte.
- R3: Reset and a master clear (write to port 8) both return the pointer to the low byte.
- R4: A write to port 9 stores `wdata[7:2]` as the mode of the channel picked by `wdata[1:0]` (00 selects ch0, 11 selects ch3). It appears on `mode_flat[6*ch +: 6]`, and the other channels keep their modes.
- R5: In a mode, bit 2 of the stored field (`wdata[4]` when written) enables autoinitialize. While it is set, a `tc_pulse` on that channel copies the base address and base count into the current registers.
- R6: While autoinitialize is off, a `tc_pulse` sets that channel's bit of `tc_status` and leaves the current registers unchanged.
- R7: A mode write whose transfer field `wdata[3:2]` is 11 sets `err_illegal`, and the bit stays set. No error is raised when `wdata[7:6]` is 11 (cascade), because the transfer field does not apply then.
- R8: A master clear zeroes every mode register, `tc_status` and `err_illegal`, and keeps the base and current address and count values.
- R9: If a host write to a channel's address or count register and a terminal-count reload of that channel happen in the same cycle, the host write wins. The written byte takes `wdata` and the reload is skipped for that channel.
- R10: After reset, all registers read 0, and `mode_flat`, `tc_status` and `err_illegal` are 0.
- R11: An `upd_en` bit loads `upd_addr` and `upd_cnt` into that channel's current registers when neither a host write nor a reload hits that channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| rd_en | input | 1 | Host byte read strobe |
| addr | input | 4 | Port code |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Addressed byte of the current register (combinational) |
| tc_pulse | input | 4 | Terminal count, one bit per channel |
| upd_en | input | 4 | Load of stepped current values, one bit per channel |
| upd_addr | input | 16 | Stepped current address |
| upd_cnt | input | 16 | Stepped current count |
| mode_flat | output | 24 | Six-bit mode of each channel, channel 0 in the low bits |
| tc_status | output | 4 | Terminal-count status per channel |
| err_illegal | output | 1 | Sticky illegal-transfer-type flag |

## Verification
If the shared pointer ends up in the wrong state, the very next read returns the other half of the register. All checks therefore clear the pointer first, or track where it stands, and compare both bytes in order. A wrong base value stays hidden until a terminal count reloads it. So the tests first move the current value away through the update port, then pulse terminal count, and read the result one cycle later. Priority faults show up only when a write and a reload land on the same edge, so that collision is driven on purpose.

// File: rtl/dma_reg_pkg.sv
// Shared constants and types for the DMA register front end.
package dma_reg_pkg;
    localparam int MODE_W  = 6;
    localparam int AI_BIT  = 2;   // autoinitialize bit inside the stored mode field
    localparam logic [3:0] PORT_MCLR   = 4'd8;
    localparam logic [3:0] PORT_MODE   = 4'd9;
    localparam logic [3:0] PORT_CLRPTR = 4'd10;

    typedef enum logic [1:0] {
        XF_VERIFY  = 2'b00,
        XF_WRITE   = 2'b01,
        XF_READ    = 2'b10,
        XF_ILLEGAL = 2'b11
    } xfer_e;

    // Stored mode field, which is wdata[7:2] of a mode-port write.
    typedef struct packed {
        logic [1:0] svc;       // service kind; 2'b11 means cascade
        logic       dir_down;  // passed on to the transfer engine
        logic       autoinit;
        xfer_e      xfer;
    } mode_t;
endpackage

// File: rtl/dma_byte_ptr.sv
// Shared low/high byte pointer.
// Assumes: clr and acc are single-cycle strobes; clr wins over acc.
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    input  logic clr,
    output logic hi_sel
);
    // Pointer state: cleared by reset or command, flipped on each access.
    always_ff @(posedge clk) begin
        if (!rst_n)   hi_sel <= 1'b0;
        else if (clr) hi_sel <= 1'b0;
        else if (acc) hi_sel <= ~hi_sel;
    end

    AST_PTR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hi_sel); // R2
    AST_PTR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !clr) |=> (hi_sel != $past(hi_sel))); // R1
endmodule

// File: rtl/dma_mode_bank.sv
// Per-channel mode registers behind one shared mode port, plus the sticky
// illegal-transfer flag.
// Assumes: the channel selector sits in the low bits of wdata and the stored
// field in wdata[7:2]; master clear wins over a mode write in the same cycle.
module dma_mode_bank
    import dma_reg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_mode,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     mclr,
    output logic [NUM_CH*MODE_W-1:0] mode_flat,
    output logic                     err_sticky
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    mode_t            new_mode;
    logic [CH_W-1:0]  sel;
    logic             illegal;

    // Decode the incoming write: target channel and whether the type is illegal.
    always_comb begin
        new_mode = mode_t'(wdata[7:2]);
        sel      = wdata[CH_W-1:0];
        illegal  = wr_mode && (new_mode.xfer == XF_ILLEGAL) && (new_mode.svc != 2'b11);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_mode
        // Mode register of channel g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_flat[g*MODE_W +: MODE_W] <= '0;
            else if (mclr)
                mode_flat[g*MODE_W +: MODE_W] <= '0;
            else if (wr_mode && (sel == CH_W'(g)))
                mode_flat[g*MODE_W +: MODE_W] <= new_mode;
        end
    end

    // Sticky error flag for a non-cascade mode write that carries the illegal type.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_sticky <= 1'b0;
        else if (mclr)    err_sticky <= 1'b0;
        else if (illegal) err_sticky <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !mclr) |=> err_sticky); // R7
    AST_CASCADE_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && (wdata[7:6] == 2'b11) && !err_sticky) |=> !err_sticky); // R7
    AST_MODE_MCLR: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (mode_flat == '0)); // R8
endmodule

// File: rtl/dma_chan_regs.sv
// Base and current address/count registers of one channel.
// Assumes: REG_W is twice DATA_W; at most one of wr_addr/wr_cnt is high;
// priority is host write, then terminal-count reload, then engine update.
module dma_chan_regs #(
    parameter int REG_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              hi_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tc,
    input  logic              autoinit,
    input  logic              mclr,
    input  logic              upd_en,
    input  logic [REG_W-1:0]  upd_addr,
    input  logic [REG_W-1:0]  upd_cnt,
    output logic [REG_W-1:0]  cur_addr,
    output logic [REG_W-1:0]  cur_cnt,
    output logic              tc_flag
);
    localparam int HI_OFS = REG_W - DATA_W;

    logic [REG_W-1:0] base_addr;
    logic [REG_W-1:0] base_cnt;
    logic             host_wr;
    int unsigned      ofs;

    // Byte offset chosen by the shared pointer, and host-write detect.
    always_comb begin
        ofs     = hi_sel ? HI_OFS : 0;
        host_wr = wr_addr || wr_cnt;
    end

    // Base copies: changed only by host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
        end else begin
            if (wr_addr) base_addr[ofs +: DATA_W] <= wdata;
            if (wr_cnt)  base_cnt[ofs +: DATA_W]  <= wdata;
        end
    end

    // Current copies: host write first, then autoinit reload, then engine update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
        end else if (host_wr) begin
            if (wr_addr) cur_addr[ofs +: DATA_W] <= wdata;
            if (wr_cnt)  cur_cnt[ofs +: DATA_W]  <= wdata;
        end else if (tc && autoinit) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
        end else if (upd_en) begin
            cur_addr <= upd_addr;
            cur_cnt  <= upd_cnt;
        end
    end

    // Terminal-count status for channels without autoinitialize.
    always_ff @(posedge clk) begin
        if (!rst_n)                 tc_flag <= 1'b0;
        else if (mclr)              tc_flag <= 1'b0;
        else if (tc && !autoinit)   tc_flag <= 1'b1;
    end

    AST_AI_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && autoinit && !host_wr) |=>
            (cur_addr == $past(base_addr)) && (cur_cnt == $past(base_cnt))); // R5
    AST_TC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !autoinit && !mclr) |=> tc_flag); // R6
    AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr |=> (($past(hi_sel) ? cur_addr[REG_W-1 -: DATA_W]
                                    : cur_addr[DATA_W-1:0]) == $past(wdata))); // R9
    AST_NOAI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !autoinit && !host_wr && !upd_en) |=>
            ($stable(cur_addr) && $stable(cur_cnt))); // R6
endmodule

// File: rtl/dma_regfile_top.sv
// Host register front end of a multi-channel DMA controller.
// Decodes byte-wide port accesses into channel registers, the mode bank and
// the command ports, and routes terminal-count and update inputs to channels.
// Assumes: one host strobe per cycle; rdata is valid combinationally.
module dma_regfile_top
    import dma_reg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int REG_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic [NUM_CH-1:0]        tc_pulse,
    input  logic [NUM_CH-1:0]        upd_en,
    input  logic [REG_W-1:0]         upd_addr,
    input  logic [REG_W-1:0]         upd_cnt,
    output logic [NUM_CH*MODE_W-1:0] mode_flat,
    output logic [NUM_CH-1:0]        tc_status,
    output logic                     err_illegal
);
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int NREG   = 2 * NUM_CH;
    localparam int HI_OFS = REG_W - DATA_W;

    logic              is_chreg, is_cnt, acc, mclr, clrptr, wr_mode, hi_sel;
    logic [CH_W-1:0]   ch_idx;
    logic [REG_W-1:0]  cur_addr_a [NUM_CH];
    logic [REG_W-1:0]  cur_cnt_a  [NUM_CH];
    logic [REG_W-1:0]  rd_reg;

    // Port decode for the current host access.
    always_comb begin
        is_chreg = (addr < ADDR_W'(NREG));
        is_cnt   = addr[0];
        ch_idx   = addr[CH_W:1];
        acc      = (wr_en || rd_en) && is_chreg;
        mclr     = wr_en && (addr == ADDR_W'(PORT_MCLR));
        clrptr   = wr_en && (addr == ADDR_W'(PORT_CLRPTR));
        wr_mode  = wr_en && (addr == ADDR_W'(PORT_MODE));
    end

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .clr    (clrptr || mclr),
        .hi_sel (hi_sel)
    );

    dma_mode_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_modes (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_mode    (wr_mode),
        .wdata      (wdata),
        .mclr       (mclr),
        .mode_flat  (mode_flat),
        .err_sticky (err_illegal)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = wr_en && is_chreg && (ch_idx == CH_W'(g));

        dma_chan_regs #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_addr  (hit && !is_cnt),
            .wr_cnt   (hit && is_cnt),
            .hi_sel   (hi_sel),
            .wdata    (wdata),
            .tc       (tc_pulse[g]),
            .autoinit (mode_flat[g*MODE_W + AI_BIT]),
            .mclr     (mclr),
            .upd_en   (upd_en[g]),
            .upd_addr (upd_addr),
            .upd_cnt  (upd_cnt),
            .cur_addr (cur_addr_a[g]),
            .cur_cnt  (cur_cnt_a[g]),
            .tc_flag  (tc_status[g])
        );
    end

    // Read mux: addressed byte of the current copy, zero for other ports.
    always_comb begin
        rd_reg = is_cnt ? cur_cnt_a[ch_idx] : cur_addr_a[ch_idx];
        rdata  = '0;
        if (is_chreg)
            rdata = hi_sel ? rd_reg[HI_OFS +: DATA_W] : rd_reg[DATA_W-1:0];
    end

    AST_MCLR_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> !hi_sel); // R3
    AST_MCLR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> ((tc_status == '0) && !err_illegal)); // R8
endmodule

// File: tb/dma_regfile_top_tb.sv
module dma_regfile_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [3:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [3:0]  tc_pulse, upd_en;
    logic [15:0] upd_addr, upd_cnt;
    logic [23:0] mode_flat;
    logic [3:0]  tc_status;
    logic        err_illegal;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dma_regfile_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tc_pulse(tc_pulse), .upd_en(upd_en),
        .upd_addr(upd_addr), .upd_cnt(upd_cnt), .mode_flat(mode_flat),
        .tc_status(tc_status), .err_illegal(err_illegal)
    );

    // Vector: {op, addr, data, expected}; op 0 = write, 1 = read and compare. (R1, R2)
    localparam logic [21:0] VEC [13] = '{
        {2'd0, 4'd10, 8'h55, 8'h00},
        {2'd0, 4'd0,  8'h34, 8'h00},
        {2'd0, 4'd0,  8'h12, 8'h00},
        {2'd1, 4'd0,  8'h00, 8'h34},
        {2'd1, 4'd0,  8'h00, 8'h12},
        {2'd0, 4'd3,  8'hCD, 8'h00},
        {2'd0, 4'd3,  8'hAB, 8'h00},
        {2'd1, 4'd3,  8'h00, 8'hCD},
        {2'd1, 4'd3,  8'h00, 8'hAB},
        {2'd0, 4'd0,  8'h77, 8'h00},
        {2'd0, 4'd10, 8'h00, 8'h00},
        {2'd1, 4'd0,  8'h00, 8'h77},
        {2'd1, 4'd0,  8'h00, 8'h12}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 chk(32'(rdata), 32'(exp), tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] v);
        wr(4'd10, 8'h00);
        wr(a, v[7:0]);
        wr(a, v[15:8]);
    endtask

    task automatic rd16(input logic [3:0] a, input logic [15:0] v, input string tag);
        wr(4'd10, 8'h00);
        rd(a, v[7:0], tag);
        rd(a, v[15:8], tag);
    endtask

    task automatic pulse(input logic [3:0] tcv, input logic [3:0] upv,
                         input logic [15:0] ua, input logic [15:0] uc);
        @(negedge clk);
        tc_pulse = tcv; upd_en = upv; upd_addr = ua; upd_cnt = uc;
        @(negedge clk);
        tc_pulse = '0; upd_en = '0;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        tc_pulse = '0; upd_en = '0; upd_addr = '0; upd_cnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        #1;
        chk(32'(rdata), 0, "R10 rdata");
        chk(32'(mode_flat), 0, "R10 mode");
        chk(32'(tc_status), 0, "R10 tc_status");
        chk(32'(err_illegal), 0, "R10 err");

        // R1 R2: table walk
        for (int i = 0; i < 13; i++) begin
            if (VEC[i][21:20] == 2'd0) wr(VEC[i][19:16], VEC[i][15:8]);
            else rd(VEC[i][19:16], VEC[i][7:0], "R1 R2 table");
        end

        // R4: mode for ch2 = type 01, autoinit on
        wr(4'd9, 8'b0001_0110);
        #1 chk(32'(mode_flat[12 +: 6]), 32'h05, "R4 ch2 mode");
        chk(32'(mode_flat[0 +: 12]), 0, "R4 other channels");

        // R11 then R5
        wr16(4'd4, 16'h1234);
        wr16(4'd5, 16'h0010);
        pulse(4'b0000, 4'b0100, 16'hAAAA, 16'h0001);
        rd16(4'd4, 16'hAAAA, "R11 update addr");
        rd16(4'd5, 16'h0001, "R11 update cnt");
        pulse(4'b0100, 4'b0000, 16'h0, 16'h0);
        rd16(4'd4, 16'h1234, "R5 reload addr");
        rd16(4'd5, 16'h0010, "R5 reload cnt");
        chk(32'(tc_status), 0, "R5 no status");

        // R6: ch1 without autoinit
        wr(4'd9, 8'b0000_0101);
        wr16(4'd2, 16'h5678);
        pulse(4'b0000, 4'b0010, 16'h1111, 16'h2222);
        pulse(4'b0010, 4'b0000, 16'h0, 16'h0);
        chk(32'(tc_status), 32'h2, "R6 status");
        rd16(4'd2, 16'h1111, "R6 addr kept");

        // R7: cascade with type 11 is not an error, plain type 11 is, and it sticks
        wr(4'd9, 8'b1100_1100);
        #1 chk(32'(err_illegal), 0, "R7 cascade");
        wr(4'd9, 8'b0000_1100);
        #1 chk(32'(err_illegal), 1, "R7 illegal");
        wr(4'd9, 8'b0000_0100);
        #1 chk(32'(err_illegal), 1, "R7 sticky");

        // R9: host write to ch2 addr collides with an autoinit reload
        pulse(4'b0000, 4'b0100, 16'hBBBB, 16'h0002);
        wr(4'd10, 8'h00);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd4; wdata = 8'h99; tc_pulse = 4'b0100;
        @(negedge clk);
        wr_en = 1'b0; tc_pulse = '0;
        rd16(4'd4, 16'hBB99, "R9 addr");
        rd16(4'd5, 16'h0002, "R9 cnt");
        pulse(4'b0100, 4'b0000, 16'h0, 16'h0);
        rd16(4'd4, 16'h1299, "R9 base written");

        // R8 R3: master clear after one access leaves the pointer low
        wr(4'd10, 8'h00);
        wr(4'd0, 8'h77);
        wr(4'd8, 8'h3C);
        rd(4'd0, 8'h77, "R3 mclr ptr");
        rd(4'd0, 8'h12, "R8 addr kept");
        chk(32'(mode_flat), 0, "R8 mode");
        chk(32'(tc_status), 0, "R8 status");
        chk(32'(err_illegal), 0, "R8 err");

        // R3: reset clears the pointer
        wr(4'd10, 8'h00);
        wr(4'd6, 8'h44);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        wr(4'd6, 8'h5A);
        wr(4'd10, 8'h00);
        rd(4'd6, 8'h5A, "R3 reset ptr");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule